// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

This block moves data between two ports, called A and B. Each direction has its own data path and its own four control pins. A path can work in three ways. It can pass data straight through while its latch enable is high. It can hold the last value it passed. It can load a new value into a flip-flop on the falling edge of its own clock, but only if that path's clock enable is low. An active-low output enable decides whether the destination port is driven. When the port is not driven it is released to high impedance.

The storage logic never sees the three-state pads. The value each path selects is always visible on a plain output vector. A separate drive flag shows whether that value is being driven. The same value also appears on an inout pad vector, and that pad floats whenever the drive flag is low. Data moves at signal level, not as transfers, so there is no valid/ready handshake and no back-pressure. A destination never stalls a source. It only sees the present level.

An asynchronous active-low reset clears both storage elements to zero, so simulation starts from a known state. Reset does not gate the output enables.

Top module: `ubt_xcvr`

## Requirements
- R1: The A-to-B path uses only `ab_le`, `ab_cp`, `ab_ce_n` and `ab_oe_n`. The B-to-A path uses only `ba_le`, `ba_cp`, `ba_ce_n` and `ba_oe_n`. Activity on one path's controls or source never changes the other path's outputs.
- R2: While a path's latch enable is 1, its value output equals its source input in the same cycle.
- R3: While the latch enable is 0 and the path clock does not fall, the value output keeps its stored value, whatever the source input does.
- R4: While the latch enable is 0, a 1-to-0 transition of the path clock with clock enable at 0 loads the source input into storage. The value output shows the new word from then on.
- R5: The output enable is active low. At 0, the drive flag is 1 and the pad carries the value output. At 1, the drive flag is 0 and the pad is high impedance. The value output and the stored word are not affected either way.
- R6: Both paths are non-inverting, and bit i of the source appears on bit i of the destination.
- R7: A falling path clock with clock enable at 1 leaves storage unchanged. A rising path clock never changes storage.
- R8: When the latch enable goes from 1 to 0, the path keeps the last word it passed through transparently.
- R9: While `rst_n` is 0, both stored words are zero, so a path with latch enable 0 shows zero. The drive flags still follow the output enables during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both stored words |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_cp | input | 1 | A-to-B clock, loads on falling edge |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_cp | input | 1 | B-to-A clock, loads on falling edge |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| a_in | input | WIDTH | Level on the A side, source of the A-to-B path |
| b_in | input | WIDTH | Level on the B side, source of the B-to-A path |
| b_out | output | WIDTH | Word selected by the A-to-B path |
| b_drv | output | 1 | 1 while the B side is driven |
| a_out | output | WIDTH | Word selected by the B-to-A path |
| a_drv | output | 1 | 1 while the A side is driven |
| a_pad | inout | WIDTH | Three-state copy of `a_out` |
| b_pad | inout | WIDTH | Three-state copy of `b_out` |

## Verification
The bench targets the points where latch and flip-flop storage interact. If the latch-enable fall does not freeze the last transparent word, the output jumps to the input applied right after the fall. If a clock edge is taken with the wrong polarity, the word appears one half-period early, on the rising edge. If the clock enable is ignored or inverted, a falling edge with the enable high loads data anyway. If the output enable gates storage instead of only the drive flag, the word is lost while the port floats. Other runs check that the A-to-B path and the B-to-A path never disturb each other, and that reset clears storage without dropping the drive flags.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  // Controls of one direction, in the order the top module packs them
  typedef struct packed {
    logic oe_n;
    logic le;
    logic cp;
    logic ce_n;
  } ubt_ctl_t;

  localparam int unsigned UBT_DIRS = 2;
  localparam int unsigned DIR_AB   = 0;
  localparam int unsigned DIR_BA   = 1;

endpackage

// File: rtl/ubt_store.sv
// Storage element of one direction: a transparent latch plus a
// falling-edge flip-flop. A pair of toggle bits records which of the
// two was written last.
module ubt_store #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             rst_n,
  input  logic             le_i,
  input  logic             cp_i,
  input  logic             ce_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] ff_q;
  logic [WIDTH-1:0] lat_q;
  logic             tog_ff;
  logic             tog_lat;
  logic             ff_newer;

  // Edge path: load on the falling clock, only with latch closed and enable low
  always_ff @(negedge cp_i or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= '0;
      tog_ff <= 1'b0;
    end else if (!le_i && !ce_n_i) begin
      ff_q   <= d_i;
      tog_ff <= ~tog_ff;
    end
  end

  // Level path: follows the source while open, and re-syncs the toggle
  always_latch begin
    if (!rst_n) begin
      lat_q   <= '0;
      tog_lat <= 1'b0;
    end else if (le_i) begin
      lat_q   <= d_i;
      tog_lat <= tog_ff;
    end
  end

  assign ff_newer = (tog_ff != tog_lat);
  assign q_o      = ff_newer ? ff_q : lat_q;

  // ---------------- checker support ----------------
  logic             seen_fall;
  logic             fall_ok;
  logic [WIDTH-1:0] fall_d;
  logic [WIDTH-1:0] q_at_rise;
  logic [WIDTH-1:0] last_open;

  always_ff @(negedge cp_i or negedge rst_n) begin
    if (!rst_n) begin
      seen_fall <= 1'b0;
      fall_ok   <= 1'b0;
      fall_d    <= '0;
    end else begin
      seen_fall <= 1'b1;
      fall_ok   <= !le_i && !ce_n_i;
      fall_d    <= d_i;
    end
  end

  always_ff @(posedge cp_i or negedge rst_n) begin
    if (!rst_n) q_at_rise <= '0;
    else        q_at_rise <= ff_q;
  end

  always_ff @(negedge le_i or negedge rst_n) begin
    if (!rst_n) last_open <= '0;
    else        last_open <= d_i;
  end

  // R4
  cap_chk: assert property (@(posedge cp_i) disable iff (!rst_n)
    (seen_fall && fall_ok) |-> (ff_q == fall_d));

  // R7
  hold_chk: assert property (@(posedge cp_i) disable iff (!rst_n)
    (seen_fall && !fall_ok) |-> (ff_q == q_at_rise));

  // R8
  close_chk: assert property (@(posedge cp_i) disable iff (!rst_n)
    (!le_i && !ff_newer) |-> (q_o == last_open));

endmodule

// File: rtl/ubt_drive.sv
// Output side of one direction: transparent bypass and the drive flag
module ubt_drive #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             le_i,
  input  logic             oe_n_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] held_i,
  output logic [WIDTH-1:0] val_o,
  output logic             drv_o
);

  always_comb begin
    val_o = le_i ? src_i : held_i;
    drv_o = ~oe_n_i;
  end

endmodule

// File: rtl/ubt_path.sv
// One direction of the transceiver
module ubt_path
  import ubt_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             rst_n,
  input  ubt_ctl_t         ctl_i,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] val_o,
  output logic             drv_o
);

  logic [WIDTH-1:0] held;

  ubt_store #(.WIDTH(WIDTH)) store_i (
    .rst_n  (rst_n),
    .le_i   (ctl_i.le),
    .cp_i   (ctl_i.cp),
    .ce_n_i (ctl_i.ce_n),
    .d_i    (src_i),
    .q_o    (held)
  );

  ubt_drive #(.WIDTH(WIDTH)) drive_i (
    .le_i   (ctl_i.le),
    .oe_n_i (ctl_i.oe_n),
    .src_i  (src_i),
    .held_i (held),
    .val_o  (val_o),
    .drv_o  (drv_o)
  );

  // R2
  transp_chk: assert property (@(posedge ctl_i.cp) disable iff (!rst_n)
    ctl_i.le |-> (val_o == src_i));

endmodule

// File: rtl/ubt_xcvr.sv
// Two-direction transceiver top
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             rst_n,
  input  logic             ab_oe_n,
  input  logic             ab_le,
  input  logic             ab_cp,
  input  logic             ab_ce_n,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_cp,
  input  logic             ba_ce_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv,
  inout  wire  [WIDTH-1:0] a_pad,
  inout  wire  [WIDTH-1:0] b_pad
);

  localparam logic [WIDTH-1:0] FLOAT = {WIDTH{1'bz}};

  ubt_ctl_t         ctl [UBT_DIRS];
  logic [WIDTH-1:0] src [UBT_DIRS];
  logic [WIDTH-1:0] val [UBT_DIRS];
  logic             drv [UBT_DIRS];

  assign ctl[DIR_AB] = '{oe_n: ab_oe_n, le: ab_le, cp: ab_cp, ce_n: ab_ce_n};
  assign ctl[DIR_BA] = '{oe_n: ba_oe_n, le: ba_le, cp: ba_cp, ce_n: ba_ce_n};
  assign src[DIR_AB] = a_in;
  assign src[DIR_BA] = b_in;

  for (genvar g = 0; g < UBT_DIRS; g++) begin : g_dir
    ubt_path #(.WIDTH(WIDTH)) path_i (
      .rst_n (rst_n),
      .ctl_i (ctl[g]),
      .src_i (src[g]),
      .val_o (val[g]),
      .drv_o (drv[g])
    );
  end

  assign b_out = val[DIR_AB];
  assign b_drv = drv[DIR_AB];
  assign a_out = val[DIR_BA];
  assign a_drv = drv[DIR_BA];

  assign b_pad = b_drv ? b_out : FLOAT;
  assign a_pad = a_drv ? a_out : FLOAT;

endmodule

// File: tb/ubt_xcvr_tb_top.sv
module ubt_xcvr_tb_top;

  localparam int W = 18;
  localparam int NV = 13;

  typedef struct packed {
    logic         le;
    logic         cp;
    logic         ce_n;
    logic         oe_n;
    logic [W-1:0] din;
    logic [W-1:0] dout;
    logic         drv;
    logic [7:0]   req;
  } vec_t;

  // A-to-B path walk; each row is applied, then checked half a cycle later
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 18'h12345, 18'h12345, 1'b1, 8'd2}, // R2
    '{1'b1, 1'b0, 1'b1, 1'b0, 18'h2AAAA, 18'h2AAAA, 1'b1, 8'd6}, // R6
    '{1'b0, 1'b0, 1'b1, 1'b0, 18'h15555, 18'h2AAAA, 1'b1, 8'd8}, // R8
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h15555, 18'h2AAAA, 1'b1, 8'd7}, // R7 rising edge
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h15555, 18'h15555, 1'b1, 8'd4}, // R4
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h3ABCD, 18'h15555, 1'b1, 8'd3}, // R3
    '{1'b0, 1'b1, 1'b1, 1'b0, 18'h3ABCD, 18'h15555, 1'b1, 8'd3}, // R3
    '{1'b0, 1'b0, 1'b1, 1'b0, 18'h3ABCD, 18'h15555, 1'b1, 8'd7}, // R7 enable high
    '{1'b0, 1'b0, 1'b1, 1'b1, 18'h3ABCD, 18'h15555, 1'b0, 8'd5}, // R5
    '{1'b1, 1'b0, 1'b1, 1'b1, 18'h3ABCD, 18'h3ABCD, 1'b0, 8'd5}, // R5
    '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00001, 18'h3ABCD, 1'b1, 8'd8}, // R8
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h20000, 18'h3ABCD, 1'b1, 8'd7}, // R7
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h20000, 18'h20000, 1'b1, 8'd4}  // R4
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic         ab_oe_n, ab_le, ab_cp, ab_ce_n;
  logic         ba_oe_n, ba_le, ba_cp, ba_ce_n;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_drv, b_drv;
  wire  [W-1:0] a_pad, b_pad;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ubt_xcvr #(.WIDTH(W)) dut_i (
    .rst_n   (rst_n),
    .ab_oe_n (ab_oe_n), .ab_le (ab_le), .ab_cp (ab_cp), .ab_ce_n (ab_ce_n),
    .ba_oe_n (ba_oe_n), .ba_le (ba_le), .ba_cp (ba_cp), .ba_ce_n (ba_ce_n),
    .a_in    (a_in),    .b_in  (b_in),
    .b_out   (b_out),   .b_drv (b_drv),
    .a_out   (a_out),   .a_drv (a_drv),
    .a_pad   (a_pad),   .b_pad (b_pad)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ab_oe_n = 1'b1; ab_le = 1'b0; ab_cp = 1'b0; ab_ce_n = 1'b1;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_cp = 1'b0; ba_ce_n = 1'b1;
    a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 b_out reset", b_out, '0);
    check("R9 a_out reset", a_out, '0);
    check("R5 b_drv idle", {17'd0, b_drv}, '0);
    @(posedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      ab_le = VECS[i].le; ab_cp = VECS[i].cp;
      ab_ce_n = VECS[i].ce_n; ab_oe_n = VECS[i].oe_n;
      #1 a_in = VECS[i].din;
      @(negedge clk);
      check($sformatf("R%0d row %0d value", VECS[i].req, i), b_out, VECS[i].dout);
      check($sformatf("R%0d row %0d drive", VECS[i].req, i), {17'd0, b_drv}, {17'd0, VECS[i].drv});
      if (VECS[i].drv) check($sformatf("R%0d row %0d pad", VECS[i].req, i), b_pad, VECS[i].dout);
    end

    // R1: the B-to-A path saw no activity
    check("R1 a_out untouched", a_out, '0);
    check("R1 a_drv untouched", {17'd0, a_drv}, '0);

    // B-to-A transparent, enabled
    @(posedge clk);
    ba_oe_n = 1'b0; ba_le = 1'b1;
    #1 b_in = 18'h1F0F0;
    @(negedge clk);
    check("R2 a_out transparent", a_out, 18'h1F0F0);
    check("R5 a_drv on", {17'd0, a_drv}, 18'd1);
    check("R5 a_pad driven", a_pad, 18'h1F0F0);
    check("R1 b_out unchanged", b_out, 18'h20000);

    // R8 on the B-to-A path
    @(posedge clk);
    ba_le = 1'b0;
    #1 b_in = 18'h00F0F;
    @(negedge clk);
    check("R8 a_out holds open word", a_out, 18'h1F0F0);

    @(posedge clk);
    ba_ce_n = 1'b0; ba_cp = 1'b1;
    @(negedge clk);
    check("R7 a_out no rising load", a_out, 18'h1F0F0);
    @(posedge clk);
    ba_cp = 1'b0;
    @(negedge clk);
    check("R4 a_out falling load", a_out, 18'h00F0F);
    check("R1 b_out still unchanged", b_out, 18'h20000);

    // R3: A source changes with latch closed and clock still
    @(posedge clk);
    a_in = 18'h3FFFF;
    @(negedge clk);
    check("R3 b_out ignores source", b_out, 18'h20000);

    // R9: reset clears storage but not the drive flags
    @(posedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 b_out cleared", b_out, '0);
    check("R9 a_out cleared", a_out, '0);
    check("R9 b_drv kept", {17'd0, b_drv}, 18'd1);
    check("R9 a_drv kept", {17'd0, a_drv}, 18'd1);
    @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 b_out after release", b_out, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule